// File: doc/BRIEF.md
# USART Data Buffer and Status

This block is the byte-wide, processor-facing buffering layer of a serial USART. It sits between a simple register bus and the transmit and receive shift engines. The bus sees two addresses. The data address has a different meaning for each direction: a write fills a one-byte transmit holding buffer, and a read pops the oldest byte from a two-entry receive FIFO. The status address returns an 8-bit word with the flags for receive-complete, transmit-complete and transmit-buffer-empty. It also returns the per-byte error flags of the byte at the head of the FIFO and two writable mode bits.

On the engine side, the transmit shift register is modelled by an idle input and a character-done pulse. When the transmitter is enabled and the shift register is idle, the block presents a load strobe with the held byte. The receive shift register delivers a byte, together with its frame-error and parity-error bits, as a one-cycle valid pulse. Turning the receiver off empties the FIFO. The bit timing, baud generation and framing of the serial line are outside this block. A character size field masks the unused upper bits in both directions.

Top module: `uart_buffer_core`

## Requirements
- R1: A bus write with bus_addr=0 while status bit 5 (transmit buffer empty) is 1 stores the byte, and status bit 5 reads 0 from the next cycle.
- R2: A bus write with bus_addr=0 while status bit 5 is 0 is discarded, so the byte later handed to the transmitter is the earlier one.
- R3: When tx_en=1, tx_idle=1 and the holding buffer is full, tx_load is 1 for that cycle with tx_data equal to the held byte, and status bit 5 returns to 1 in the next cycle. When tx_en=0, tx_load stays 0.
- R4: Status bit 6 (transmit complete) sets in the cycle after a tx_done pulse that arrives while the holding buffer is empty. A tx_done pulse while the buffer is full leaves it unchanged. A status write (bus_addr=1) with data bit 6 = 1 clears it. If a set and a clear fall in the same cycle, the set wins.
- R5: A bus read with bus_addr=0 returns the oldest unread received byte and removes it, so bytes are read back in arrival order.
- R6: Status bit 7 (receive complete) is 1 exactly when the FIFO holds at least one unread byte.
- R7: A byte that arrives while the FIFO holds two entries, with no data read in the same cycle, is dropped. The overrun flag (status bit 3) is then attached to the newest stored entry and is seen when that entry reaches the head.
- R8: Status bits 4 (frame error) and 2 (parity error) show the flags that arrived with the byte at the FIFO head. Bits 4, 3 and 2 are 0 when the FIFO is empty.
- R9: While rx_en=0 the FIFO is emptied from the next cycle, arriving bytes are ignored, and status bit 7 reads 0.
- R10: char_size selects 5, 6, 7 or 8 data bits (2'b00, 2'b01, 2'b10, 2'b11). Bits above the size are cleared in bytes written for transmit and in bytes stored on receive.
- R11: After reset the status word reads 8'h20 and tx_load is 0.
- R12: Status bits 1 (double speed) and 0 (multiprocessor mode) take the written value on a status write and read it back. Writes have no effect on bits 7, 5, 4, 3 and 2.
- R13: A data read while the FIFO is empty returns 8'h00 and leaves the FIFO empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | 0 selects the data address, 1 selects the status word |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe; a read of the data address pops the FIFO |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data, combinational from bus_addr |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable; low flushes the FIFO |
| char_size | input | 2 | Character size: 00=5, 01=6, 10=7, 11=8 bits |
| tx_idle | input | 1 | Transmit shift register is empty and can accept a byte |
| tx_done | input | 1 | Pulse: the transmit shift register finished a character |
| tx_load | output | 1 | Strobe: tx_data is transferred to the shift register this cycle |
| tx_data | output | 8 | Byte handed to the transmit shift register |
| rx_valid | input | 1 | Pulse: a received byte is offered |
| rx_data | input | 8 | Received byte |
| rx_ferr | input | 1 | Frame error of the received byte |
| rx_perr | input | 1 | Parity error of the received byte |

## Verification
The receive FIFO is driven with random mixes of arrivals, reads and both in one cycle, and every read and every status flag is compared with a bench model. These mixes separate correct pop-then-push ordering from ordering bugs, and accepted arrivals from overruns. Directed sequences fill the FIFO past its depth, read it when empty and drop the receive enable with bytes waiting; these tell a misplaced overrun flag, a missing flush or a popping empty read apart from correct behaviour. On the transmit side, a second write while the buffer is full, tx_done with the buffer both full and empty, a clear coinciding with a set, and each character size show whether the write guard, the flag priority and the masking hold.

// File: rtl/uart_buf_pkg.sv
`timescale 1ns/1ps
package uart_buf_pkg;

    localparam int unsigned CHAR_W  = 8;
    localparam int unsigned MIN_CHR = 5;
    localparam int unsigned TXC_BIT = 6;
    localparam int unsigned DBL_BIT = 1;
    localparam int unsigned MPM_BIT = 0;

    typedef logic [CHAR_W-1:0] char_t;

    typedef enum logic [1:0] {
        CS_5 = 2'b00,
        CS_6 = 2'b01,
        CS_7 = 2'b10,
        CS_8 = 2'b11
    } char_size_e;

    // one receive FIFO slot: byte plus the flags that travel with it
    typedef struct packed {
        char_t data;
        logic  ferr;
        logic  ovr;
        logic  perr;
    } rx_entry_t;

    // status word, most significant field first (bit 7 down to bit 0)
    typedef struct packed {
        logic rxc;
        logic txc;
        logic udre;
        logic ferr;
        logic ovr;
        logic perr;
        logic dbl;
        logic mpm;
    } status_t;

    function automatic char_t mask_char(char_t d, char_size_e sz);
        char_t keep;
        keep = char_t'((32'd1 << (MIN_CHR + int'(sz))) - 32'd1);
        return d & keep;
    endfunction

endpackage

// File: rtl/uart_tx_hold.sv
`timescale 1ns/1ps
module uart_tx_hold
    import uart_buf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_req,
    input  char_t      wr_data,
    input  char_size_e size,
    input  logic       tx_en,
    input  logic       tx_idle,
    output logic       empty,
    output logic       tx_load,
    output char_t      tx_data
);

    logic  full_q;
    char_t hold_q;

    assign empty   = ~full_q;
    assign tx_load = full_q & tx_en & tx_idle;
    assign tx_data = hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            hold_q <= '0;
        end else if (tx_load) begin
            full_q <= 1'b0;
        end else if (wr_req && !full_q) begin
            full_q <= 1'b1;
            hold_q <= mask_char(wr_data, size);
        end
    end

endmodule

// File: rtl/uart_rx_fifo.sv
`timescale 1ns/1ps
module uart_rx_fifo
    import uart_buf_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      flush,
    input  logic      push,
    input  rx_entry_t push_entry,
    input  logic      pop_req,
    output rx_entry_t head,
    output logic      nonempty
);

    localparam int unsigned CW = $clog2(DEPTH + 1);

    rx_entry_t       ent   [DEPTH];
    rx_entry_t       nxt   [DEPTH];
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   cnt_mid;
    logic [CW-1:0]   cnt_n;
    logic            pop;
    logic            full;
    logic            accept;
    logic            ovr;

    assign nonempty = (cnt != '0);
    assign head     = nonempty ? ent[0] : '0;

    always_comb begin
        pop     = pop_req && nonempty;
        full    = (cnt == CW'(DEPTH));
        accept  = push && (!full || pop);
        ovr     = push && full && !pop;
        nxt     = ent;
        cnt_mid = cnt;
        // pop first: shift toward the head
        if (pop) begin
            for (int i = 0; i < int'(DEPTH) - 1; i++) begin
                nxt[i] = ent[i+1];
            end
            nxt[DEPTH-1] = '0;
            cnt_mid      = cnt - CW'(1);
        end
        cnt_n = cnt_mid;
        // then append behind the surviving entries
        if (accept) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                if (CW'(i) == cnt_mid) begin
                    nxt[i] = push_entry;
                end
            end
            cnt_n = cnt_mid + CW'(1);
        end
        // lost byte: mark the newest stored entry
        if (ovr) begin
            nxt[DEPTH-1].ovr = 1'b1;
        end
        if (flush) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                nxt[i] = '0;
            end
            cnt_n = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                ent[i] <= '0;
            end
            cnt <= '0;
        end else begin
            ent <= nxt;
            cnt <= cnt_n;
        end
    end

endmodule

// File: rtl/uart_stat_ctl.sv
`timescale 1ns/1ps
module uart_stat_ctl (
    input  logic clk,
    input  logic rst,
    input  logic wr_stat,
    input  logic wr_txc_clr,
    input  logic wr_dbl,
    input  logic wr_mpm,
    input  logic tx_done,
    input  logic hold_empty,
    output logic txc,
    output logic dbl,
    output logic mpm
);

    logic txc_set;

    assign txc_set = tx_done && hold_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            txc <= 1'b0;
            dbl <= 1'b0;
            mpm <= 1'b0;
        end else begin
            if (txc_set) begin
                txc <= 1'b1;
            end else if (wr_stat && wr_txc_clr) begin
                txc <= 1'b0;
            end
            if (wr_stat) begin
                dbl <= wr_dbl;
                mpm <= wr_mpm;
            end
        end
    end

endmodule

// File: rtl/uart_buffer_core.sv
`timescale 1ns/1ps
module uart_buffer_core
    import uart_buf_pkg::*;
#(
    parameter int unsigned RX_DEPTH = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        tx_en,
    input  logic        rx_en,
    input  logic [1:0]  char_size,
    input  logic        tx_idle,
    input  logic        tx_done,
    output logic        tx_load,
    output logic [7:0]  tx_data,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_ferr,
    input  logic        rx_perr
);

    char_size_e size;
    logic       wr_data_q;
    logic       wr_stat;
    logic       rd_pop;
    logic       hold_empty;
    logic       txc_flag;
    logic       dbl;
    logic       mpm;
    logic       rx_nonempty;
    rx_entry_t  push_entry;
    rx_entry_t  head;
    status_t    st;

    assign size      = char_size_e'(char_size);
    assign wr_data_q = bus_wr && !bus_addr;
    assign wr_stat   = bus_wr && bus_addr;
    assign rd_pop    = bus_rd && !bus_addr;

    always_comb begin
        push_entry      = '0;
        push_entry.data = mask_char(rx_data, size);
        push_entry.ferr = rx_ferr;
        push_entry.perr = rx_perr;
    end

    uart_tx_hold u_tx (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (wr_data_q),
        .wr_data (bus_wdata),
        .size    (size),
        .tx_en   (tx_en),
        .tx_idle (tx_idle),
        .empty   (hold_empty),
        .tx_load (tx_load),
        .tx_data (tx_data)
    );

    uart_rx_fifo #(.DEPTH(RX_DEPTH)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .flush      (!rx_en),
        .push       (rx_valid && rx_en),
        .push_entry (push_entry),
        .pop_req    (rd_pop),
        .head       (head),
        .nonempty   (rx_nonempty)
    );

    uart_stat_ctl u_st (
        .clk        (clk),
        .rst        (rst),
        .wr_stat    (wr_stat),
        .wr_txc_clr (bus_wdata[TXC_BIT]),
        .wr_dbl     (bus_wdata[DBL_BIT]),
        .wr_mpm     (bus_wdata[MPM_BIT]),
        .tx_done    (tx_done),
        .hold_empty (hold_empty),
        .txc        (txc_flag),
        .dbl        (dbl),
        .mpm        (mpm)
    );

    always_comb begin
        st      = '0;
        st.rxc  = rx_nonempty;
        st.txc  = txc_flag;
        st.udre = hold_empty;
        st.ferr = head.ferr;
        st.ovr  = head.ovr;
        st.perr = head.perr;
        st.dbl  = dbl;
        st.mpm  = mpm;
    end

    assign bus_rdata = bus_addr ? char_t'(st) : head.data;

endmodule

// File: rtl/uart_buf_chk.sv
`timescale 1ns/1ps
module uart_buf_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic       tx_done,
    input logic       tx_load,
    input logic       rx_en,
    input logic       hold_empty,
    input logic       txc_flag,
    input logic       rx_nonempty
);

    p_fill_r1: assert property (@(posedge clk) disable iff (rst)
        (hold_empty && bus_wr && !bus_addr) |=> !hold_empty);

    p_hold_kept_r2: assert property (@(posedge clk) disable iff (rst)
        (!hold_empty && !tx_load) |=> !hold_empty);

    p_empty_after_load_r3: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> (hold_empty && !tx_load));

    p_txc_set_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_done && hold_empty) |=> txc_flag);

    p_txc_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (!(tx_done && hold_empty) && bus_wr && bus_addr && bus_wdata[6]) |=> !txc_flag);

    p_flush_r9: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !rx_nonempty);

    p_reset_state_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (hold_empty && !txc_flag && !rx_nonempty));

endmodule

bind uart_buffer_core uart_buf_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .tx_done     (tx_done),
    .tx_load     (tx_load),
    .rx_en       (rx_en),
    .hold_empty  (hold_empty),
    .txc_flag    (txc_flag),
    .rx_nonempty (rx_nonempty)
);

// File: tb/tb_uart_buffer_core.sv
`timescale 1ns/1ps
module tb_uart_buffer_core;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_addr, bus_wr, bus_rd;
    logic [7:0] bus_wdata, bus_rdata;
    logic       tx_en, rx_en;
    logic [1:0] char_size;
    logic       tx_idle, tx_done, tx_load;
    logic [7:0] tx_data;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_ferr, rx_perr;

    int n_chk  = 0;
    int n_fail = 0;

    // bench model of the receive FIFO
    logic [7:0] m_d  [2];
    logic       m_fe [2];
    logic       m_pe [2];
    logic       m_ov [2];
    int         m_n;

    always #4 clk = ~clk;

    uart_buffer_core dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_en(tx_en), .rx_en(rx_en),
        .char_size(char_size), .tx_idle(tx_idle), .tx_done(tx_done), .tx_load(tx_load),
        .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ferr(rx_ferr),
        .rx_perr(rx_perr)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(logic a, logic [7:0] d);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 1'b0;
    endtask

    task automatic rd_data(output logic [7:0] d);
        bus_addr = 1'b0; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(output logic [7:0] s);
        bus_addr = 1'b1; bus_rd = 1'b1;
        #1 s = bus_rdata;
        bus_rd = 1'b0; bus_addr = 1'b0;
    endtask

    task automatic push(logic [7:0] d, logic fe, logic pe);
        rx_valid = 1'b1; rx_data = d; rx_ferr = fe; rx_perr = pe;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pulse_done();
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic model_clear();
        m_n = 0;
        for (int i = 0; i < 2; i++) begin
            m_d[i] = 8'h00; m_fe[i] = 1'b0; m_pe[i] = 1'b0; m_ov[i] = 1'b0;
        end
    endtask

    task automatic model_step(logic v, logic r, logic [7:0] d, logic fe, logic pe);
        if (r && m_n > 0) begin
            m_d[0] = m_d[1]; m_fe[0] = m_fe[1]; m_pe[0] = m_pe[1]; m_ov[0] = m_ov[1];
            m_d[1] = 8'h00; m_fe[1] = 1'b0; m_pe[1] = 1'b0; m_ov[1] = 1'b0;
            m_n--;
        end
        if (v) begin
            if (m_n < 2) begin
                m_d[m_n] = d; m_fe[m_n] = fe; m_pe[m_n] = pe; m_ov[m_n] = 1'b0;
                m_n++;
            end else begin
                m_ov[1] = 1'b1;
            end
        end
    endtask

    function automatic logic [7:0] exp_rx_flags();
        if (m_n == 0) return 8'h00;
        return {1'b1, 2'b00, m_fe[0], m_ov[0], m_pe[0], 2'b00};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [7:0] s;
        logic [7:0] d;
        int unsigned seed_val;
        seed_val = $urandom(32'h5eed);
        rst = 1'b1; bus_addr = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = 8'h00;
        tx_en = 1'b0; rx_en = 1'b1; char_size = 2'b11; tx_idle = 1'b0; tx_done = 1'b0;
        rx_valid = 1'b0; rx_data = 8'h00; rx_ferr = 1'b0; rx_perr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        peek(s); check("R11 status after reset", s, 8'h20);
        #1 check("R11 tx_load after reset", {7'd0, tx_load}, 8'h00);

        // R1 fill holding buffer
        wr(1'b0, 8'hA5);
        peek(s); check("R1 buffer-empty bit after write", s & 8'h20, 8'h00);
        // R2 second write discarded
        wr(1'b0, 8'h3C);
        // R4 tx_done with buffer full does not set
        pulse_done();
        peek(s); check("R4 no set while buffer full", s & 8'h40, 8'h00);
        // R3 disabled transmitter does not load
        tx_idle = 1'b1;
        #1 check("R3 no load when disabled", {7'd0, tx_load}, 8'h00);
        @(negedge clk);
        tx_en = 1'b1;
        #1 check("R3 load strobe", {7'd0, tx_load}, 8'h01);
        check("R2 first byte kept", tx_data, 8'hA5);
        @(negedge clk);
        tx_idle = 1'b0;
        #1 check("R3 single load", {7'd0, tx_load}, 8'h00);
        peek(s); check("R3 buffer empty again", s & 8'h20, 8'h20);

        // R10 transmit masking, 5 bits
        char_size = 2'b00;
        wr(1'b0, 8'hFF);
        tx_idle = 1'b1;
        #1 check("R10 tx 5-bit mask", tx_data, 8'h1F);
        @(negedge clk);
        tx_idle = 1'b0;
        char_size = 2'b11;

        // R4 / R12 status register
        pulse_done();
        peek(s); check("R4 txc set", s, 8'h60);
        wr(1'b1, 8'hFF);
        peek(s); check("R4 R12 clear txc, set mode bits", s, 8'h23);
        wr(1'b1, 8'h00);
        peek(s); check("R12 mode bits cleared", s, 8'h20);
        wr(1'b1, 8'hBC);
        peek(s); check("R12 read-only bits ignore write", s, 8'h20);
        tx_done = 1'b1;
        wr(1'b1, 8'h40);
        tx_done = 1'b0;
        peek(s); check("R4 set wins over clear", s & 8'h40, 8'h40);
        wr(1'b1, 8'h40);

        // R5 R6 R8 two-entry order and flags
        push(8'h11, 1'b1, 1'b0);
        push(8'h22, 1'b0, 1'b1);
        peek(s); check("R6 R8 head flags first", s & 8'h9C, 8'h90);
        rd_data(d); check("R5 oldest byte", d, 8'h11);
        peek(s); check("R8 head flags second", s & 8'h9C, 8'h84);
        rd_data(d); check("R5 second byte", d, 8'h22);
        peek(s); check("R6 R8 empty flags", s & 8'h9C, 8'h00);

        // R13 empty read
        rd_data(d); check("R13 empty read value", d, 8'h00);
        push(8'h33, 1'b0, 1'b0);
        rd_data(d); check("R13 fifo unchanged by empty read", d, 8'h33);
        peek(s); check("R13 empty after single", s & 8'h80, 8'h00);

        // R7 overrun
        push(8'hA1, 1'b0, 1'b0);
        push(8'hB2, 1'b0, 1'b0);
        push(8'hC3, 1'b0, 1'b0);
        peek(s); check("R7 head has no overrun", s & 8'h9C, 8'h80);
        rd_data(d); check("R7 first kept", d, 8'hA1);
        peek(s); check("R7 overrun on newest entry", s & 8'h9C, 8'h88);
        rd_data(d); check("R7 second kept", d, 8'hB2);
        peek(s); check("R7 third dropped", s & 8'h80, 8'h00);

        // R9 flush
        push(8'h44, 1'b0, 1'b0);
        push(8'h55, 1'b0, 1'b0);
        rx_en = 1'b0;
        push(8'h66, 1'b0, 1'b0);
        rx_en = 1'b1;
        peek(s); check("R9 flushed rxc", s & 8'h9C, 8'h00);
        rd_data(d); check("R9 flushed data", d, 8'h00);

        // R10 receive masking
        char_size = 2'b01;
        push(8'hFF, 1'b0, 1'b0);
        rd_data(d); check("R10 rx 6-bit mask", d, 8'h3F);
        char_size = 2'b10;
        push(8'hFF, 1'b0, 1'b0);
        rd_data(d); check("R10 rx 7-bit mask", d, 8'h7F);
        char_size = 2'b11;

        // R5 R7 R8 random mix against the model
        model_clear();
        for (int it = 0; it < 600; it++) begin
            logic v, r, fe, pe;
            logic [7:0] rd8;
            v = 1'($urandom_range(0, 1));
            r = 1'($urandom_range(0, 2) == 0);
            fe = 1'($urandom_range(0, 1));
            pe = 1'($urandom_range(0, 1));
            rd8 = 8'($urandom);
            rx_valid = v; rx_data = rd8; rx_ferr = fe; rx_perr = pe;
            bus_addr = 1'b0; bus_rd = r;
            #1;
            if (r) check("R5 random read", bus_rdata, (m_n > 0) ? m_d[0] : 8'h00);
            @(negedge clk);
            rx_valid = 1'b0; bus_rd = 1'b0;
            model_step(v, r, rd8, fe, pe);
            peek(s); check("R7 R8 random flags", s & 8'h9C, exp_rx_flags());
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule